// File: doc/BRIEF.md
# Prioritised Interrupt Qualifier

The qualifier sits between a set of peripheral request wires and a processor's exception sequencer. Each cycle it decides whether any interrupt should be presented and, if so, which one. Ordinary request lines each carry a fixed numeric priority, set at build time through a packed parameter. Such a line can compete only when its priority is strictly above the processor's current priority level, which software may rewrite. A single global mask input blocks every ordinary line at once.

A separate non-maskable request is latched on its rising edge and stays pending until the sequencer acknowledges it. It disregards the ordinary mask and the current priority level. Only its own dedicated mask input holds it back, and while that mask is set the request stays latched rather than being dropped.

The result is registered. It consists of a take flag and an identifier. The identifier is the winning line index, or the dedicated code equal to the number of ordinary lines when the non-maskable source wins. The identifier reads zero whenever nothing is taken.

Top module: `irq_qualifier`

## Requirements
- R1: While reset is high, and on the first cycle after it is released, `take_irq` is 0 and `take_id` is 0, and no non-maskable request is pending.
- R2: An ordinary line can be taken only if its priority is strictly greater than `cur_prio`. A line whose priority equals `cur_prio` is not taken.
- R3: While `irq_mask` is 1, no ordinary line is taken, whatever the requests and `cur_prio` are.
- R4: When several lines are eligible, the one with the greatest priority is reported in `take_id`. The default line priorities, for lines 0 to 7, are 1, 3, 3, 5, 2, 7, 5 and 4.
- R5: When the top eligible priority is shared by several lines, the lowest line index among them wins.
- R6: Ordinary requests are level-sensitive. Inputs sampled at a clock edge set the outputs at that same edge. A request that is withdrawn stops being reported one cycle later.
- R7: A 0-to-1 transition of `nmi_req` sets a pending flag. From the next edge on, `take_irq` is 1 with `take_id` equal to 8, the number of lines. This holds until an edge where `nmi_ack` is sampled high. After that edge the flag is clear, and outputs computed at later edges no longer show it.
- R8: A pending non-maskable request is taken regardless of `irq_mask` and `cur_prio`. While `nmi_mask` is 1 it is not presented, but it stays pending and appears once `nmi_mask` returns to 0.
- R9: A pending, unmasked non-maskable request takes precedence over any ordinary line.
- R10: Whenever `take_irq` is 0, `take_id` is 0.
- R11: Holding `nmi_req` high does not set the pending flag again after an acknowledge. Only a fresh rising edge does.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_req | input | 8 | Ordinary level-sensitive request lines |
| cur_prio | input | 3 | Processor's current priority level |
| irq_mask | input | 1 | Global block for ordinary lines |
| nmi_req | input | 1 | Non-maskable request, edge-detected |
| nmi_mask | input | 1 | Dedicated block for the non-maskable source |
| nmi_ack | input | 1 | Clears the latched non-maskable request |
| take_irq | output | 1 | Registered: an interrupt is to be taken |
| take_id | output | 4 | Registered winning line index, or 8 for the non-maskable source |

## Verification
The assertions assume that `nmi_req` stays low while reset is asserted, so that no rising edge is hidden inside reset. They also assume that every input is stable around each rising clock edge, since the edge detector and the output stage sample the inputs there. The bench drives all inputs only on falling edges and holds `nmi_req` at 0 throughout reset. It draws random request patterns, priority levels, masks and acknowledges inside those limits, and adds directed cases for equality of priorities, ties and the non-maskable latch.

// File: rtl/irq_qual_pkg.sv
package irq_qual_pkg;

    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_LINE = 2'd1,
        SRC_NMI  = 2'd2
    } grant_src_e;

    // Identifier width: line indices 0..n-1 plus one code for the NMI source.
    function automatic int unsigned code_width(input int unsigned n);
        return $clog2(n + 1);
    endfunction

endpackage

// File: rtl/irq_prio_arbiter.sv
module irq_prio_arbiter #(
    parameter int unsigned NUM_LINES = 8,
    parameter int unsigned PRIO_W    = 3,
    parameter int unsigned ID_W      = 4,
    parameter logic [NUM_LINES*PRIO_W-1:0] LINE_PRIO = '0
) (
    input  logic [NUM_LINES-1:0] req,
    input  logic [PRIO_W-1:0]    cur_prio,
    output logic                 found,
    output logic [ID_W-1:0]      win_idx
);
    logic [PRIO_W-1:0]    prio_tbl [NUM_LINES];
    logic [NUM_LINES-1:0] elig;

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        assign prio_tbl[g] = LINE_PRIO[g*PRIO_W +: PRIO_W];
        assign elig[g]     = req[g] && (prio_tbl[g] > cur_prio);
    end

    // Scan from the top index down; ">=" lets a lower index displace an equal one.
    logic [PRIO_W-1:0] best;
    always_comb begin
        found   = 1'b0;
        best    = '0;
        win_idx = '0;
        for (int i = NUM_LINES - 1; i >= 0; i--) begin
            if (elig[i] && (!found || prio_tbl[i] >= best)) begin
                found   = 1'b1;
                best    = prio_tbl[i];
                win_idx = ID_W'(i);
            end
        end
    end

endmodule

// File: rtl/irq_nmi_latch.sv
module irq_nmi_latch (
    input  logic clk,
    input  logic rst,
    input  logic nmi_req,
    input  logic nmi_ack,
    output logic pending
);
    logic req_q;
    logic rise;

    assign rise = nmi_req && !req_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q   <= 1'b0;
            pending <= 1'b0;
        end else begin
            req_q <= nmi_req;
            if (rise)
                pending <= 1'b1;
            else if (nmi_ack)
                pending <= 1'b0;
        end
    end

    p_edge_sets_r7: assert property (@(posedge clk) disable iff (rst)
        (nmi_req && !req_q) |=> pending);

    p_ack_clears_r7: assert property (@(posedge clk) disable iff (rst)
        (nmi_ack && !(nmi_req && !req_q)) |=> !pending);

    p_no_retrigger_r11: assert property (@(posedge clk) disable iff (rst)
        (!pending && !(nmi_req && !req_q)) |=> !pending);

endmodule

// File: rtl/irq_qualifier.sv
module irq_qualifier
    import irq_qual_pkg::*;
#(
    parameter int unsigned NUM_LINES = 8,
    parameter int unsigned PRIO_W    = 3,
    parameter logic [NUM_LINES*PRIO_W-1:0] LINE_PRIO = 24'h97AAD9,
    localparam int unsigned ID_W     = code_width(NUM_LINES)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_LINES-1:0] irq_req,
    input  logic [PRIO_W-1:0]    cur_prio,
    input  logic                 irq_mask,
    input  logic                 nmi_req,
    input  logic                 nmi_mask,
    input  logic                 nmi_ack,
    output logic                 take_irq,
    output logic [ID_W-1:0]      take_id
);
    localparam logic [ID_W-1:0] NMI_CODE = ID_W'(NUM_LINES);

    logic            line_found;
    logic [ID_W-1:0] line_idx;
    logic            nmi_pending;
    grant_src_e      src;

    irq_prio_arbiter #(
        .NUM_LINES (NUM_LINES),
        .PRIO_W    (PRIO_W),
        .ID_W      (ID_W),
        .LINE_PRIO (LINE_PRIO)
    ) u_arb (
        .req      (irq_req),
        .cur_prio (cur_prio),
        .found    (line_found),
        .win_idx  (line_idx)
    );

    irq_nmi_latch u_nmi (
        .clk     (clk),
        .rst     (rst),
        .nmi_req (nmi_req),
        .nmi_ack (nmi_ack),
        .pending (nmi_pending)
    );

    always_comb begin
        if (nmi_pending && !nmi_mask)
            src = SRC_NMI;
        else if (line_found && !irq_mask)
            src = SRC_LINE;
        else
            src = SRC_NONE;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            take_irq <= 1'b0;
            take_id  <= '0;
        end else begin
            unique case (src)
                SRC_NMI: begin
                    take_irq <= 1'b1;
                    take_id  <= NMI_CODE;
                end
                SRC_LINE: begin
                    take_irq <= 1'b1;
                    take_id  <= line_idx;
                end
                default: begin
                    take_irq <= 1'b0;
                    take_id  <= '0;
                end
            endcase
        end
    end

    p_idle_code_r10: assert property (@(posedge clk) disable iff (rst)
        !take_irq |-> (take_id == '0));

    p_both_masked_r3: assert property (@(posedge clk) disable iff (rst)
        (irq_mask && nmi_mask) |=> !take_irq);

    p_line_unmasked_r3: assert property (@(posedge clk) disable iff (rst)
        (take_irq && take_id != NMI_CODE) |-> !$past(irq_mask));

    p_nmi_unmasked_r8: assert property (@(posedge clk) disable iff (rst)
        (take_irq && take_id == NMI_CODE) |-> !$past(nmi_mask));

endmodule

// File: tb/irq_qualifier_bench.sv
module irq_qualifier_bench;
    localparam int N  = 8;
    localparam int PW = 3;
    localparam logic [N*PW-1:0] PRIOS = 24'h97AAD9;
    localparam logic [3:0] NMI_ID = 4'd8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [N-1:0] irq_req = '0;
    logic [PW-1:0] cur_prio = '0;
    logic         irq_mask = 1'b0;
    logic         nmi_req = 1'b0;
    logic         nmi_mask = 1'b0;
    logic         nmi_ack = 1'b0;
    logic         take_irq;
    logic [3:0]   take_id;

    int n_tests = 0;
    int n_fail  = 0;
    bit m_pend  = 1'b0;
    bit m_prev  = 1'b0;
    bit done    = 1'b0;

    always #10 clk = ~clk;

    irq_qualifier u_irq_qualifier (
        .clk(clk), .rst(rst), .irq_req(irq_req), .cur_prio(cur_prio),
        .irq_mask(irq_mask), .nmi_req(nmi_req), .nmi_mask(nmi_mask),
        .nmi_ack(nmi_ack), .take_irq(take_irq), .take_id(take_id)
    );

    function automatic logic [4:0] ref_out(input logic [N-1:0] r, input logic [PW-1:0] cp,
                                           input logic im, input logic nm, input bit pend);
        logic          hit;
        logic [PW-1:0] top;
        logic [3:0]    idx;
        hit = 1'b0; top = '0; idx = '0;
        if (pend && !nm) return {1'b1, NMI_ID};
        if (im) return 5'd0;
        for (int i = 0; i < N; i++) begin
            logic [PW-1:0] p;
            p = PRIOS[i*PW +: PW];
            if (r[i] && p > cp && (!hit || p > top)) begin
                hit = 1'b1; top = p; idx = 4'(i);
            end
        end
        return hit ? {1'b1, idx} : 5'd0;
    endfunction

    task automatic check(input string tag, input logic [4:0] got, input logic [4:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: take/id got %0b/%0d expected %0b/%0d",
                     tag, got[4], got[3:0], exp[4], exp[3:0]);
        end
    endtask

    task automatic cyc(input logic [N-1:0] r, input logic [PW-1:0] cp, input logic im,
                       input logic nm, input logic nr, input logic ak, input string tag);
        logic [4:0] exp;
        @(negedge clk);
        irq_req = r; cur_prio = cp; irq_mask = im;
        nmi_mask = nm; nmi_req = nr; nmi_ack = ak;
        @(posedge clk);
        exp = ref_out(r, cp, im, nm, m_pend);
        m_pend = (nr && !m_prev) || (m_pend && !ak);
        m_prev = nr;
        #1;
        check(tag, {take_irq, take_id}, exp);
    endtask

    initial begin
        #(20ns * 200000);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        // R1: reset state
        irq_req = 8'hFF; nmi_mask = 1'b0;
        repeat (3) @(posedge clk);
        #1 check("R1 in reset", {take_irq, take_id}, 5'd0);
        @(negedge clk); rst = 1'b0;
        cyc(8'h00, 3'd0, 0, 0, 0, 0, "R1 after reset");

        // R2: strict greater-than (line 3 has priority 5)
        cyc(8'h08, 3'd5, 0, 0, 0, 0, "R2 equal blocked");
        cyc(8'h08, 3'd4, 0, 0, 0, 0, "R2 greater taken");
        // R3: global mask
        cyc(8'hFF, 3'd0, 1, 0, 0, 0, "R3 masked");
        // R4: lines 0,1,5 -> line 5 (priority 7)
        cyc(8'h23, 3'd0, 0, 0, 0, 0, "R4 highest");
        // R5: ties
        cyc(8'h06, 3'd0, 0, 0, 0, 0, "R5 tie lines 1,2");
        cyc(8'h48, 3'd2, 0, 0, 0, 0, "R5 tie lines 3,6");
        // R6 / R10: withdraw
        cyc(8'h00, 3'd0, 0, 0, 0, 0, "R6 withdrawn R10 idle id");
        // R7 / R11: NMI latch
        cyc(8'h00, 3'd0, 0, 0, 1, 0, "R7 rise edge cycle");
        cyc(8'h00, 3'd0, 0, 0, 1, 0, "R7 nmi presented");
        cyc(8'h00, 3'd0, 0, 0, 1, 1, "R7 ack cycle");
        cyc(8'h00, 3'd0, 0, 0, 1, 0, "R7 cleared");
        cyc(8'h00, 3'd0, 0, 0, 1, 0, "R11 held high no retrigger");
        // R8: mask-independent, own mask holds it
        cyc(8'h00, 3'd7, 1, 0, 0, 0, "R8 drop req");
        cyc(8'h00, 3'd7, 1, 1, 1, 0, "R8 rise while masked");
        cyc(8'h00, 3'd7, 1, 1, 1, 0, "R8 held masked");
        cyc(8'h00, 3'd7, 1, 0, 1, 0, "R8 unmasked taken");
        // R9: precedence over line 5
        cyc(8'h20, 3'd0, 0, 0, 1, 0, "R9 nmi over line");
        cyc(8'h20, 3'd0, 0, 0, 0, 1, "R9 ack");
        cyc(8'h20, 3'd0, 0, 0, 0, 0, "R6 line after nmi");

        // Random mix covering R2..R11
        for (int k = 0; k < 3000; k++) begin
            cyc(8'($urandom), 3'($urandom), ($urandom % 4) == 0, ($urandom % 5) == 0,
                ($urandom % 6) == 0, ($urandom % 4) == 0, "R4 random");
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule